// File: doc/BRIEF.md
# Symmetric Half-Rate FIR Decimator

This block is a linear-phase FIR filter that halves the sample rate. It is meant for the back end of a digital down-converter. It can serve either as the stage that flattens the passband droop of a cascaded integrator-comb decimator or as the last channel-shaping filter. Samples arrive as signed words with a one-cycle valid strobe. Each accepted sample enters a delay line. On every second accepted sample the block forms one convolution against a fixed coefficient table and presents the result, reduced to the output width, together with a one-cycle output strobe.

The impulse response is symmetric by construction. Only the first half of the table, plus the centre tap when the tap count is odd, is supplied through the `COEFS` parameter. Mirrored sample pairs are added before each multiply, which halves the multiplier count. The accumulator carries full precision. The final result is scaled down by `2^SHIFT`, rounded to nearest and clamped to the signed output range. Tap count, widths, scale and table are all parameters; the defaults are 21 taps, 20-bit data, 16-bit coefficients and a scale of 14.

Top module: `fir_decim2`

## Requirements
- R1: Exactly one result is produced for every two accepted inputs. `out_valid` is high for one cycle, in the cycle that follows the clock edge accepting the second input of each pair, and is never high in two consecutive cycles.
- R2: While `rst_n` is low, the delay line clears to zero, the pair phase restarts, `out_valid` is 0 and `out_data` is 0. After reset the first result follows the second accepted input.
- R3: Cycles with `in_valid` low are ignored. They do not shift the delay line, do not advance the pair phase, and leave `out_valid` low in the following cycle.
- R4: The result for the accepted input with index n (counting from 0 after reset; n is odd) is the full-precision sum over k of c[k]·x[n−k], with x taken as 0 before the first input. The taps are c[k] = c[NTAPS−1−k], where c[k] for k < (NTAPS+1)/2 is the signed 16-bit field `COEFS[16k +: 16]`.
- R5: The sum is divided by 2^SHIFT and rounded to nearest, with exact halves going toward +infinity. With the default table, a single input of +4096 at index 0 gives +28 at index 3, and −4096 gives −27.
- R6: A rounded value above +524287 yields +524287, and one below −524288 yields −524288. Results are never wrapped.
- R7: `out_data` holds the last result unchanged in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Signed, rounded and saturated result |

## Verification
The assertions assume that `in_valid` is driven low for as long as `rst_n` is low. They also assume that `in_valid` is never unknown once reset is released, because the pair-parity reference in the checker advances on every sampled strobe. The bench meets both conditions: it holds the strobe low around each reset, it drives every input on the falling clock edge from a single task, and it never leaves the inputs undriven. The stimulus mixes back-to-back inputs with idle gaps, so the parity reference and the hold checks are exercised with both spacings.

// File: rtl/fir_decim2.sv
module fir_decim2 #(
  parameter int IN_W   = 20,
  parameter int OUT_W  = 20,
  parameter int COEF_W = 16,
  parameter int NTAPS  = 21,
  parameter int SHIFT  = 14,
  parameter logic [COEF_W*((NTAPS+1)/2)-1:0] COEFS = {
    16'h4000, 16'hF1F0, 16'hFECA, 16'h04B0, 16'h015E, 16'hFE7A,
    16'hFF4C, 16'h006E, 16'h003C, 16'hFFDD, 16'hFFEC}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int NHALF  = (NTAPS + 1) / 2;
  localparam bit ODD    = (NTAPS % 2) == 1;
  localparam int PRE_W  = IN_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NHALF) + 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) << (OUT_W - 1));

  logic signed [IN_W-1:0]   dly  [NTAPS-1];
  logic signed [IN_W-1:0]   win  [NTAPS];
  logic signed [PROD_W-1:0] prod [NHALF];
  logic                     phase;
  logic signed [ACC_W-1:0]  acc, rnd, scaled;
  logic signed [OUT_W-1:0]  clipped;

  assign win[0] = in_data;
  for (genvar k = 1; k < NTAPS; k++) begin : g_win
    assign win[k] = dly[k-1];
  end

  for (genvar k = 0; k < NHALF; k++) begin : g_tap
    logic signed [PRE_W-1:0]  pre;
    logic signed [COEF_W-1:0] cf;
    assign cf = COEFS[k*COEF_W +: COEF_W];
    if (ODD && k == NHALF - 1) begin : g_mid
      assign pre = {win[k][IN_W-1], win[k]};
    end else begin : g_pair
      assign pre = {win[k][IN_W-1], win[k]} + {win[NTAPS-1-k][IN_W-1], win[NTAPS-1-k]};
    end
    assign prod[k] = pre * cf;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NHALF; k++) acc = acc + ACC_W'(prod[k]);
  end

  assign rnd     = acc + HALF;
  assign scaled  = rnd >>> SHIFT;
  assign clipped = (scaled > MAXV) ? MAXV[OUT_W-1:0] :
                   (scaled < MINV) ? MINV[OUT_W-1:0] : scaled[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS - 1; k++) dly[k] <= '0;
      phase     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        dly[0] <= in_data;
        for (int k = 1; k < NTAPS - 1; k++) dly[k] <= dly[k-1];
        phase <= ~phase;
        if (phase) begin
          out_valid <= 1'b1;
          out_data  <= clipped;
        end
      end
    end
  end
endmodule

// File: rtl/fir_decim2_chk.sv
module fir_decim2_chk #(
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  logic par;

  always_ff @(posedge clk) begin
    if (!rst_n) par <= 1'b0;
    else if (in_valid) par <= ~par;
  end

  p_second_of_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && $past(par)));

  p_pair_emits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(par)) |-> out_valid);

  p_no_back_to_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && out_data == '0));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind fir_decim2 fir_decim2_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data));

// File: tb/fir_decim2_bench.sv
module fir_decim2_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [19:0] in_data = '0;
  logic               out_valid;
  logic signed [19:0] out_data;

  int errors = 0;
  int checks = 0;
  int cnt = 0;
  int hist [0:4095];
  bit exp_v = 1'b0;
  longint exp_d = 0;

  always #4 clk = ~clk;

  fir_decim2 u_fir_decim2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  function automatic longint coef(int k);
    int h [0:10] = '{-20, -35, 60, 110, -180, -390, 350, 1200, -310, -3600, 16384};
    return longint'(h[(k <= 10) ? k : 20 - k]);
  endfunction

  function automatic longint model(int n);
    longint s = 0;
    for (int k = 0; k < 21; k++)
      if (n - k >= 0) s += coef(k) * longint'(hist[n-k]);
    s = (s + 8192) >>> 14;
    if (s > 524287) s = 524287;
    if (s < -524288) s = -524288;
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(bit v, int x, string req);
    @(negedge clk);
    check(out_valid == exp_v, {req, " strobe"}, longint'(out_valid), longint'(exp_v));
    check(longint'(out_data) == exp_d, {req, " data"}, longint'(out_data), exp_d);
    in_valid = v;
    in_data  = 20'(x);
    exp_v    = 1'b0;
    if (v) begin
      hist[cnt] = x;
      if (cnt % 2 == 1) begin
        exp_v = 1'b1;
        exp_d = model(cnt);
      end
      cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cnt = 0; exp_v = 1'b0; exp_d = 0;
  endtask

  task automatic t_reset_r2();
    step(1, 100000, "R2");
    step(1, -5000, "R2");
    step(1, 300000, "R2");
    do_reset();
    step(0, 0, "R2");
    step(1, 7000, "R2");
    step(0, 0, "R2");
    step(1, 0, "R2");
    step(0, 0, "R2");
  endtask

  task automatic t_impulse_r4();
    do_reset();
    step(1, 16384, "R4");
    for (int i = 0; i < 24; i++) step(1, 0, "R4");
    step(1, 0, "R4");
    step(1, 16384, "R4");
    for (int i = 0; i < 24; i++) step(1, 0, "R4");
    step(0, 0, "R4");
  endtask

  task automatic t_round_r5(int amp, longint want);
    do_reset();
    step(1, amp, "R5");
    for (int i = 0; i < 3; i++) step(1, 0, "R5");
    step(0, 0, "R5");
    check(longint'(out_data) == want, "R5 tie", longint'(out_data), want);
  endtask

  task automatic t_sat_r6(bit pos);
    longint want = pos ? 524287 : -524288;
    do_reset();
    step(1, 0, "R6");
    for (int i = 1; i <= 21; i++) begin
      bit up = (coef(21 - i) >= 0) ~^ pos;
      step(1, up ? 524287 : -524288, "R6");
    end
    step(0, 0, "R6");
    check(longint'(out_data) == want, "R6 clamp", longint'(out_data), want);
  endtask

  task automatic t_gaps_r3();
    do_reset();
    for (int i = 0; i < 30; i++) begin
      step(1, (i * 37911) % 400000 - 200000, "R3");
      for (int g = 0; g < i % 4; g++) step(0, 12345, "R3 R7");
    end
    step(0, 0, "R3");
  endtask

  task automatic t_stream_r1();
    logic [19:0] lf = 20'h5A5A5;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      lf = {lf[18:0], lf[19] ^ lf[16]};
      step(1, int'($signed(lf)), "R1 R4");
    end
    step(0, 0, "R1");
    step(0, 0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    t_reset_r2();
    t_impulse_r4();
    t_round_r5(4096, 28);
    t_round_r5(-4096, -27);
    t_sat_r6(1'b1);
    t_sat_r6(1'b0);
    t_gaps_r3();
    t_stream_r1();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule